// File: doc/BRIEF.md
# SDRAM Bank and Refresh Sequencer

This block sits between a request front end and an SDRAM command bus. Each request is a read or a write that names a bank, a row and a column. The block turns each request into the legal command sequence for the device. It keeps a table of the open row in every bank. A request to a row that is already open goes straight to its column command. A request to a closed bank first opens the row, then waits the row-to-column delay. A request to a different row first closes the bank, then opens the new row. The block drives one command per cycle on the command bus and models no data path.

A free-running interval timer marks a refresh as due. The sequencer lets any command sequence already in progress finish. It then closes all banks, waits the precharge time, and issues an auto-refresh. It keeps the request port stalled until the refresh recovery time has passed. A strobe reports when read data is expected, a fixed number of cycles after each read command. All delays are parameters in clock cycles.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, cmd_o is NOP (0), req_ready_o is 1, rd_valid_o is 0 and every bank is closed, so the first access to any bank starts with an activate.
- R2: A request to a closed bank issues ACT (1) with the row on cmd_addr_o. The read (RD, 2) or write (WR, 3) to the column follows exactly T_RCD cycles later, with NOP in between.
- R3: A request to the row already open in its bank issues its RD or WR in the cycle after acceptance, with no ACT or PCH.
- R4: A request to a bank whose open row differs issues PCH (4) to that bank. ACT to the new row follows exactly T_RP cycles later, and the column command follows T_RCD cycles after the ACT.
- R5: Banks are tracked independently. Opening or changing a row in one bank does not alter the hit or miss outcome for another bank.
- R6: With no traffic, PCHA (5) is issued once every REF_INTERVAL cycles. REF (6) follows each PCHA after exactly T_RP cycles, and no other command is issued within T_RFC cycles after a REF.
- R7: A refresh that becomes due while a request's command sequence is in progress waits for that sequence's column command. PCHA then follows in the next cycle.
- R8: After a PCHA every bank is closed, so an access to a row that was open before the refresh issues ACT, not a column command or PCH.
- R9: req_ready_o is low from the cycle PCHA is issued until T_RFC cycles after the REF. A request held valid during this time is not accepted until ready returns.
- R10: rd_valid_o is high exactly CAS_LAT cycles after each RD on the command bus. Writes produce no strobe.
- R11: cmd_bank_o carries the target bank for ACT, RD, WR and PCH. cmd_addr_o carries the row for ACT and the column for RD and WR, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| cmd_o | output | 3 | Command code: NOP 0, ACT 1, RD 2, WR 3, PCH 4, PCHA 5, REF 6 |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_addr_o | output | ADDR_W | Row or column address |
| rd_valid_o | output | 1 | Read data expected this cycle |

## Verification
The hardest case to reach is a refresh that falls due while a row-conflict sequence is part-way between its precharge and its column command. No port shows the timer's phase. To reach it, the bench first lets the block idle and measures the exact cycle of two successive refreshes. From that it knows when the next timer expiry falls. It then presents a conflicting request so that the expiry lands between the PCH and the ACT. It checks that the column command is still issued on time and that the refresh follows in the next cycle. The bench sweeps every bank against every row in a small configuration. A bench model of the open-row table predicts hit, miss or conflict for each access and clears itself on each observed PCHA.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PCH  = 3'd4,
    CMD_PCHA = 3'd5,
    CMD_REF  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RP,
    ST_RCD,
    ST_RFP,
    ST_RFC
  } seq_st_e;
endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int INTERVAL = 1560,
  localparam int CW = $clog2(INTERVAL + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CW'(INTERVAL - 1);
    else if (cnt_q == '0) cnt_q <= CW'(INTERVAL - 1);
    else                  cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_row_table.sv
module sdram_row_table #(
  parameter int N_BANKS = 4,
  parameter int ROW_W   = 13,
  localparam int BANK_W = $clog2(N_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic              open_o,
  output logic [ROW_W-1:0]  row_o,
  input  logic              set_i,
  input  logic [BANK_W-1:0] set_bank_i,
  input  logic [ROW_W-1:0]  set_row_i,
  input  logic              clr_all_i
);
  logic [N_BANKS-1:0] open_q;
  logic [ROW_W-1:0]   row_q [N_BANKS];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (clr_all_i) begin
        open_q[b] <= 1'b0;
      end else if (set_i && set_bank_i == BANK_W'(b)) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= set_row_i;
      end
    end
  end

  assign open_o = open_q[rd_bank_i];
  assign row_o  = row_q[rd_bank_i];
endmodule

// File: rtl/sdram_cas_pipe.sv
module sdram_cas_pipe #(
  parameter int LAT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  output logic rd_valid_o
);
  logic [LAT-1:0] sr_q;

  if (LAT == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= rd_i;
    end
  end else begin : g_many
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[LAT-2:0], rd_i};
    end
  end

  assign rd_valid_o = sr_q[LAT-1];
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int N_BANKS      = 4,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 15,
  parameter int CAS_LAT      = 4,
  parameter int REF_INTERVAL = 1560,
  localparam int BANK_W = $clog2(N_BANKS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              rd_valid_o
);
  localparam int T_MAX = (T_RFC > T_RCD) ? ((T_RFC > T_RP) ? T_RFC : T_RP)
                                         : ((T_RCD > T_RP) ? T_RCD : T_RP);
  localparam int CW = $clog2(T_MAX + 1);

  seq_st_e           st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              due_q, tick, take_ref;
  logic              q_wr;
  logic [BANK_W-1:0] q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col;
  logic              latch;
  logic              tbl_open, tbl_set, tbl_clr;
  logic [ROW_W-1:0]  tbl_row;
  logic [BANK_W-1:0] set_bank;
  logic [ROW_W-1:0]  set_row;
  cmd_e              cmd_n;
  logic [BANK_W-1:0] bank_n;
  logic [ADDR_W-1:0] addr_n;

  sdram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  sdram_row_table #(.N_BANKS(N_BANKS), .ROW_W(ROW_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_bank_i(req_bank_i), .open_o(tbl_open), .row_o(tbl_row),
    .set_i(tbl_set), .set_bank_i(set_bank), .set_row_i(set_row),
    .clr_all_i(tbl_clr)
  );

  sdram_cas_pipe #(.LAT(CAS_LAT)) u_cas (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_i(cmd_o == CMD_RD), .rd_valid_o(rd_valid_o)
  );

  assign req_ready_o = (st_q == ST_IDLE) && !due_q;
  assign set_bank    = (st_q == ST_IDLE) ? req_bank_i : q_bank;
  assign set_row     = (st_q == ST_IDLE) ? req_row_i  : q_row;

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    cmd_n    = CMD_NOP;
    bank_n   = '0;
    addr_n   = '0;
    tbl_set  = 1'b0;
    tbl_clr  = 1'b0;
    take_ref = 1'b0;
    latch    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (due_q) begin
          cmd_n    = CMD_PCHA;
          tbl_clr  = 1'b1;
          take_ref = 1'b1;
          st_n     = ST_RFP;
          cnt_n    = CW'(T_RP - 1);
        end else if (req_valid_i) begin
          latch  = 1'b1;
          bank_n = req_bank_i;
          if (tbl_open && tbl_row == req_row_i) begin
            cmd_n  = req_write_i ? CMD_WR : CMD_RD;
            addr_n = ADDR_W'(req_col_i);
          end else if (tbl_open) begin
            cmd_n = CMD_PCH;
            st_n  = ST_RP;
            cnt_n = CW'(T_RP - 1);
          end else begin
            cmd_n   = CMD_ACT;
            addr_n  = ADDR_W'(req_row_i);
            tbl_set = 1'b1;
            st_n    = ST_RCD;
            cnt_n   = CW'(T_RCD - 1);
          end
        end
      end
      ST_RP: begin
        if (cnt_q == '0) begin
          cmd_n   = CMD_ACT;
          bank_n  = q_bank;
          addr_n  = ADDR_W'(q_row);
          tbl_set = 1'b1;
          st_n    = ST_RCD;
          cnt_n   = CW'(T_RCD - 1);
        end else cnt_n = cnt_q - 1'b1;
      end
      ST_RCD: begin
        if (cnt_q == '0) begin
          cmd_n  = q_wr ? CMD_WR : CMD_RD;
          bank_n = q_bank;
          addr_n = ADDR_W'(q_col);
          st_n   = ST_IDLE;
        end else cnt_n = cnt_q - 1'b1;
      end
      ST_RFP: begin
        if (cnt_q == '0) begin
          cmd_n = CMD_REF;
          st_n  = ST_RFC;
          cnt_n = CW'(T_RFC - 1);
        end else cnt_n = cnt_q - 1'b1;
      end
      ST_RFC: begin
        if (cnt_q == '0) st_n = ST_IDLE;
        else             cnt_n = cnt_q - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      due_q      <= 1'b0;
      q_wr       <= 1'b0;
      q_bank     <= '0;
      q_row      <= '0;
      q_col      <= '0;
      cmd_o      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_addr_o <= '0;
    end else begin
      st_q       <= st_n;
      cnt_q      <= cnt_n;
      due_q      <= tick | (due_q & ~take_ref);
      cmd_o      <= cmd_n;
      cmd_bank_o <= bank_n;
      cmd_addr_o <= addr_n;
      if (latch) begin
        q_wr   <= req_write_i;
        q_bank <= req_bank_i;
        q_row  <= req_row_i;
        q_col  <= req_col_i;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int N_BANKS = 4,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 15,
  localparam int BANK_W = $clog2(N_BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank_o
);
  logic [N_BANKS-1:0] open_q;
  int act_age [N_BANKS];
  int pch_age [N_BANKS];
  int ref_age, pcha_age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q   <= '0;
      ref_age  <= T_RFC;
      pcha_age <= T_RP;
      for (int b = 0; b < N_BANKS; b++) begin
        act_age[b] <= T_RCD;
        pch_age[b] <= T_RP;
      end
    end else begin
      for (int b = 0; b < N_BANKS; b++) begin
        if (cmd_o == CMD_ACT && cmd_bank_o == BANK_W'(b)) begin
          act_age[b] <= 1;
          open_q[b]  <= 1'b1;
        end else if (act_age[b] < T_RCD) act_age[b] <= act_age[b] + 1;
        if ((cmd_o == CMD_PCH && cmd_bank_o == BANK_W'(b)) || cmd_o == CMD_PCHA) begin
          pch_age[b] <= 1;
          open_q[b]  <= 1'b0;
        end else if (pch_age[b] < T_RP) pch_age[b] <= pch_age[b] + 1;
      end
      if (cmd_o == CMD_REF)      ref_age <= 1;
      else if (ref_age < T_RFC)  ref_age <= ref_age + 1;
      if (cmd_o == CMD_PCHA)     pcha_age <= 1;
      else if (pcha_age < T_RP)  pcha_age <= pcha_age + 1;
    end
  end

  a_r2_col_after_rcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> act_age[cmd_bank_o] >= T_RCD);
  a_r3_col_on_open_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> open_q[cmd_bank_o]);
  a_r4_act_after_rp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> pch_age[cmd_bank_o] >= T_RP);
  a_r4_act_on_closed_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> !open_q[cmd_bank_o]);
  a_r6_ref_after_pcha: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> pcha_age >= T_RP);
  a_r6_quiet_after_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP) |-> ref_age >= T_RFC);
  a_r9_stall_in_rfc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_age < T_RFC) |-> !req_ready_o);
  a_r9_stall_on_pcha: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PCHA) |-> !req_ready_o);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .N_BANKS(N_BANKS), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o)
);

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;
  localparam int NB = 4, RW = 3, CLW = 4;
  localparam int TRCD = 3, TRP = 2, TRFC = 5, CL = 3, RI = 200;
  localparam int BW = 2, AW = 4;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PCH = 3'd4, C_PCHA = 3'd5, C_REF = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [BW-1:0]  req_bank = '0;
  logic [RW-1:0]  req_row = '0;
  logic [CLW-1:0] req_col = '0;
  logic [2:0]     cmd;
  logic [BW-1:0]  cmd_bank;
  logic [AW-1:0]  cmd_addr;
  logic           rd_valid;

  int nchk = 0, nfail = 0, cyc = 0;
  int last_pcha = -1000, last_ref = -1000, last_col = 0;
  bit m_open [NB];
  int m_row  [NB];
  logic [CL-1:0] hist = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_cmd_seq #(
    .N_BANKS(NB), .ROW_W(RW), .COL_W(CLW), .T_RCD(TRCD), .T_RP(TRP),
    .T_RFC(TRFC), .CAS_LAT(CL), .REF_INTERVAL(RI)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr),
    .rd_valid_o(rd_valid)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s @%0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // Command bus monitor: refresh timing, read strobe, model clear on PCHA
  always @(negedge clk) if (rst_n) begin
    chk(rd_valid == hist[CL-1], "R10", "rd_valid", rd_valid, hist[CL-1]);
    hist = {hist[CL-2:0], cmd == C_RD};
    if (cmd != C_NOP && cmd != C_REF && cyc - last_ref < TRFC)
      chk(0, "R6", "command inside tRFC", cyc - last_ref, TRFC);
    if (cmd == C_REF) begin
      chk(cyc - last_pcha == TRP, "R6", "PCHA to REF gap", cyc - last_pcha, TRP);
      last_ref = cyc;
    end
    if (cmd == C_PCHA) begin
      last_pcha = cyc;
      for (int b = 0; b < NB; b++) m_open[b] = 0;
    end
  end

  task automatic see(logic [2:0] ec, int eb, int ea, string req);
    @(negedge clk);
    chk(cmd == ec, req, "cmd", cmd, ec);
    if (ec != C_NOP) chk(cmd_bank == BW'(eb), req, "bank", cmd_bank, eb);
    if (ec == C_ACT || ec == C_RD || ec == C_WR)
      chk(cmd_addr == AW'(ea), req, "addr", cmd_addr, ea);
  endtask

  task automatic access(int b, int r, int c, bit w, string hit_tag, string miss_tag);
    int kind;
    #1;
    req_bank = BW'(b); req_row = RW'(r); req_col = CLW'(c); req_write = w;
    req_valid = 1'b1;
    while (!req_ready) begin @(negedge clk); #1; end
    kind = m_open[b] ? ((m_row[b] == r) ? 0 : 2) : 1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (kind == 2) begin
      see(C_PCH, b, 0, "R4");
      for (int i = 0; i < TRP - 1; i++) see(C_NOP, 0, 0, "R4");
      see(C_ACT, b, r, "R4");
    end
    if (kind == 1) see(C_ACT, b, r, miss_tag);
    if (kind != 0) for (int i = 0; i < TRCD - 1; i++) see(C_NOP, 0, 0, miss_tag);
    see(w ? C_WR : C_RD, b, c, (kind == 0) ? hit_tag : (kind == 2 ? "R4" : miss_tag));
    m_open[b] = 1; m_row[b] = r;
    last_col = cyc;
  endtask

  task automatic wait_pcha(output int at);
    @(negedge clk);
    while (cmd != C_PCHA) @(negedge clk);
    at = cyc;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int p0, p1;
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd == C_NOP, "R1", "cmd after reset", cmd, C_NOP);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    for (int b = 0; b < NB; b++) access(b, 7 - b, b, 1'b0, "R1", "R1");

    // R5 banks independent: reopen each bank, then hit all of them
    for (int b = 0; b < NB; b++) access(b, b, 2 * b, b[0], "R5", "R2");
    for (int b = 0; b < NB; b++) access(b, b, 15 - b, ~b[0], "R5", "R2");

    // Sweep all rows across all banks, each followed by a hit
    for (int r = 0; r < (1 << RW); r++)
      for (int b = 0; b < NB; b++) begin
        access(b, (r + b) % (1 << RW), r + b, r[0], "R3", "R2");
        access(b, (r + b) % (1 << RW), 15 - r, ~r[0], "R3", "R2");
      end

    // R6 idle refresh cadence
    wait_pcha(p0);
    wait_pcha(p1);
    chk(p1 - p0 == RI, "R6", "PCHA interval", p1 - p0, RI);

    // R7 refresh due in the middle of a conflict sequence
    access(0, 1, 3, 1'b0, "R3", "R8");
    while (cyc != p1 + RI - 4) @(negedge clk);
    access(0, 2, 5, 1'b1, "R3", "R2");
    chk(last_col == p1 + RI + 2, "R7", "column cycle", last_col, p1 + RI + 2);
    @(negedge clk);
    chk(cmd == C_PCHA, "R7", "PCHA after column", cmd, C_PCHA);
    chk(cyc == last_col + 1, "R7", "PCHA cycle", cyc, last_col + 1);

    // R9 stall and R8 banks closed after refresh
    repeat (TRP + TRFC + 2) @(negedge clk);
    access(1, 5, 9, 1'b0, "R3", "R2");
    access(1, 5, 9, 1'b0, "R3", "R2");
    wait_pcha(p0);
    #1;
    req_bank = 2'd1; req_row = 3'd5; req_col = 4'd6; req_write = 1'b0;
    req_valid = 1'b1;
    for (int k = 0; k < TRP + TRFC; k++) begin
      chk(req_ready == 1'b0, "R9", "ready during refresh", req_ready, 0);
      chk(cmd == C_NOP || cmd == C_PCHA || cmd == C_REF, "R9", "cmd during stall", cmd, 0);
      @(negedge clk);
      #1;
    end
    chk(req_ready == 1'b1, "R9", "ready after tRFC", req_ready, 1);
    chk(cyc == p0 + TRP + TRFC, "R9", "ready cycle", cyc, p0 + TRP + TRFC);
    @(negedge clk);
    chk(cmd == C_ACT, "R8", "ACT for formerly open row", cmd, C_ACT);
    chk(cmd_addr == AW'(5), "R11", "row on addr", cmd_addr, 5);
    for (int i = 0; i < TRCD - 1; i++) @(negedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(cmd == C_RD, "R2", "read after tRCD", cmd, C_RD);
    chk(cmd_addr == AW'(6), "R11", "col on addr", cmd_addr, 6);
    m_open[1] = 1; m_row[1] = 5;
    repeat (CL + 2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule